// File: doc/BRIEF.md
# Width-Selectable Integer ALU

This block carries out the integer register-register and register-immediate operations of a 64-bit processor. The issue logic presents an 8-bit opcode, two 64-bit operands and a valid strobe. The second operand holds either a register value or an immediate that has already been decoded and widened to 64 bits. One clock later the block returns a 64-bit result together with a valid flag.

The opcode selects the operation and also the lane width of 8, 16, 32 or 64 bits. Each sized family uses four consecutive opcodes in the order 8, 16, 32, 64. Sized results wrap within their lane and the bits above the lane read as zero. A comparison puts a three-way ordering value into the result instead of setting flags.

Top module: `wsel_int_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `out_res` changes only on those results and otherwise holds its last value.
- R2: Add (0x03..0x06) and subtract (0x07..0x0A) wrap modulo 2^N for lane width N = 8, 16, 32, 64 in opcode order. Result bits above the lane are zero.
- R3: Multiply (0x0B..0x0E) returns the low N bits of the product, zero-extended, with the lane width ordered as in R2.
- R4: AND, OR and XOR (0x0F, 0x10, 0x11) act on all 64 bits.
- R5: Left shift (0x12..0x15), logical right shift (0x16..0x19) and arithmetic right shift (0x1A..0x1D) work on the low N bits of operand a. The shift amount is operand b modulo N. The arithmetic shift fills with bit N-1. Result bits above the lane are zero.
- R6: 0x1E compares a and b as unsigned 64-bit values and 0x1F as signed values. The result is all ones when a<b, 0 when they are equal, and 1 when a>b.
- R7: 0x28 returns the bitwise complement of a. 0x29 returns 1 when a is zero and 0 otherwise.
- R8: 0x2A, 0x2B and 0x2C sign-extend the low 8, 16 and 32 bits of a to 64 bits.
- R9: The immediate forms take operand b as the immediate:
  - add: 0x2D..0x30
  - multiply: 0x31..0x34
  - AND/OR/XOR: 0x35..0x37
  - left shift: 0x38..0x3B
  - logical right shift: 0x3C..0x3F
  - arithmetic right shift: 0x40..0x43
  - unsigned compare: 0x44
  - signed compare: 0x45

  Each behaves like its register form.
- R10: 0x46 returns a. 0x48..0x4B return the low 8, 16, 32 or 64 bits of b, zero-extended.
- R11: Every other opcode, including 0x00..0x02, 0x20..0x27, 0x47 and 0x4C..0xFF, returns zero.
- R12: While reset is asserted, `out_valid` and `out_res` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 8 | Opcode |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand or decoded immediate |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 64 | Result |

## Verification
Several properties are checked by assertions on every cycle:
- the one-cycle valid latency and the holding of the result between operations;
- the zero upper bits of sized results;
- a comparison never producing anything but all ones, 0 or 1;
- logical negation returning only 0 or 1.

The numeric value of each operation can only be shown by the bench scenarios, which compare results against an independent model. These scenarios cover:
- wrap at each lane width;
- shift amounts at or beyond the lane width;
- arithmetic fill from the lane's sign bit;
- signed and unsigned ordering of the same bit patterns;
- opcodes that have no assigned operation.

// File: rtl/wsel_alu_pkg.sv
package wsel_alu_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned OPLEN = 8;

  typedef enum logic [4:0] {
    K_NONE, K_ADD, K_SUB, K_MUL, K_AND, K_OR, K_XOR,
    K_SHL, K_SHR, K_SAR, K_CMPU, K_CMPS, K_CPL, K_LNOT,
    K_SEXT, K_MOVA, K_MOVB
  } alu_kind_e;

  // lane code: 0=8, 1=16, 2=32, 3=64 bits
  typedef logic [1:0] lane_t;

  function automatic int unsigned lane_bits(lane_t w);
    return 8 << w;
  endfunction

  function automatic logic [XLEN-1:0] lane_mask(lane_t w);
    logic [XLEN-1:0] m;
    m = '1;
    if (w != 2'd3) m = (XLEN'(1) << lane_bits(w)) - XLEN'(1);
    return m;
  endfunction

  function automatic logic [XLEN-1:0] lane_sext(logic [XLEN-1:0] v, lane_t w);
    logic [XLEN-1:0] r;
    case (w)
      2'd0:    r = {{(XLEN-8){v[7]}}, v[7:0]};
      2'd1:    r = {{(XLEN-16){v[15]}}, v[15:0]};
      2'd2:    r = {{(XLEN-32){v[31]}}, v[31:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic [5:0] lane_shamt(logic [5:0] b, lane_t w);
    logic [5:0] r;
    case (w)
      2'd0:    r = b & 6'd7;
      2'd1:    r = b & 6'd15;
      2'd2:    r = b & 6'd31;
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic kind_sized(alu_kind_e k);
    return k inside {K_ADD, K_SUB, K_MUL, K_SHL, K_SHR, K_SAR, K_MOVB};
  endfunction
endpackage

// File: rtl/wsel_decode.sv
module wsel_decode
  import wsel_alu_pkg::*;
(
  input  logic [OPLEN-1:0] op,
  output alu_kind_e        kind,
  output lane_t            lane
);
  always_comb begin
    kind = K_NONE;
    lane = 2'd3;
    if (op >= 8'h03 && op <= 8'h06)      begin kind = K_ADD;  lane = lane_t'(op - 8'h03); end
    else if (op >= 8'h07 && op <= 8'h0A) begin kind = K_SUB;  lane = lane_t'(op - 8'h07); end
    else if (op >= 8'h0B && op <= 8'h0E) begin kind = K_MUL;  lane = lane_t'(op - 8'h0B); end
    else if (op == 8'h0F || op == 8'h35) kind = K_AND;
    else if (op == 8'h10 || op == 8'h36) kind = K_OR;
    else if (op == 8'h11 || op == 8'h37) kind = K_XOR;
    else if (op >= 8'h12 && op <= 8'h15) begin kind = K_SHL;  lane = lane_t'(op - 8'h12); end
    else if (op >= 8'h16 && op <= 8'h19) begin kind = K_SHR;  lane = lane_t'(op - 8'h16); end
    else if (op >= 8'h1A && op <= 8'h1D) begin kind = K_SAR;  lane = lane_t'(op - 8'h1A); end
    else if (op == 8'h1E || op == 8'h44) kind = K_CMPU;
    else if (op == 8'h1F || op == 8'h45) kind = K_CMPS;
    else if (op == 8'h28)                kind = K_CPL;
    else if (op == 8'h29)                kind = K_LNOT;
    else if (op >= 8'h2A && op <= 8'h2C) begin kind = K_SEXT; lane = lane_t'(op - 8'h2A); end
    else if (op >= 8'h2D && op <= 8'h30) begin kind = K_ADD;  lane = lane_t'(op - 8'h2D); end
    else if (op >= 8'h31 && op <= 8'h34) begin kind = K_MUL;  lane = lane_t'(op - 8'h31); end
    else if (op >= 8'h38 && op <= 8'h3B) begin kind = K_SHL;  lane = lane_t'(op - 8'h38); end
    else if (op >= 8'h3C && op <= 8'h3F) begin kind = K_SHR;  lane = lane_t'(op - 8'h3C); end
    else if (op >= 8'h40 && op <= 8'h43) begin kind = K_SAR;  lane = lane_t'(op - 8'h40); end
    else if (op == 8'h46)                kind = K_MOVA;
    else if (op >= 8'h48 && op <= 8'h4B) begin kind = K_MOVB; lane = lane_t'(op - 8'h48); end
  end
endmodule

// File: rtl/wsel_arith.sv
module wsel_arith
  import wsel_alu_pkg::*;
(
  input  alu_kind_e       kind,
  input  lane_t           lane,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [XLEN-1:0] raw;
  always_comb begin
    case (kind)
      K_ADD:   raw = a + b;
      K_SUB:   raw = a - b;
      K_MUL:   raw = a * b;
      default: raw = '0;
    endcase
    y = raw & lane_mask(lane);
  end
endmodule

// File: rtl/wsel_shift.sv
module wsel_shift
  import wsel_alu_pkg::*;
(
  input  alu_kind_e       kind,
  input  lane_t           lane,
  input  logic [XLEN-1:0] a,
  input  logic [5:0]      amt,
  output logic [XLEN-1:0] y
);
  logic [5:0]      shamt_eff;
  logic [XLEN-1:0] src_zx;
  logic [XLEN-1:0] src_sx;
  always_comb begin
    shamt_eff = lane_shamt(amt, lane);
    src_zx    = a & lane_mask(lane);
    src_sx    = lane_sext(a, lane);
    case (kind)
      K_SHL:   y = (src_zx << shamt_eff) & lane_mask(lane);
      K_SHR:   y = src_zx >> shamt_eff;
      K_SAR:   y = XLEN'($signed(src_sx) >>> shamt_eff) & lane_mask(lane);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/wsel_misc.sv
module wsel_misc
  import wsel_alu_pkg::*;
(
  input  alu_kind_e       kind,
  input  lane_t           lane,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic cmp_lt, cmp_eq;
  always_comb begin
    cmp_eq = (a == b);
    cmp_lt = (kind == K_CMPS) ? ($signed(a) < $signed(b)) : (a < b);
    case (kind)
      K_AND:          y = a & b;
      K_OR:           y = a | b;
      K_XOR:          y = a ^ b;
      K_CMPU, K_CMPS: y = cmp_lt ? '1 : (cmp_eq ? '0 : XLEN'(1));
      K_CPL:          y = ~a;
      K_LNOT:         y = XLEN'(a == '0);
      K_SEXT:         y = lane_sext(a, lane);
      K_MOVA:         y = a;
      K_MOVB:         y = b & lane_mask(lane);
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/wsel_int_alu.sv
module wsel_int_alu
  import wsel_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPLEN-1:0] in_op,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_res
);
  alu_kind_e       dec_kind;
  lane_t           dec_lane;
  logic [XLEN-1:0] y_arith, y_shift, y_misc, y_sel;
  alu_kind_e       lat_kind;
  lane_t           lat_lane;

  wsel_decode u_dec (.op(in_op), .kind(dec_kind), .lane(dec_lane));
  wsel_arith  u_ari (.kind(dec_kind), .lane(dec_lane), .a(in_a), .b(in_b), .y(y_arith));
  wsel_shift  u_shf (.kind(dec_kind), .lane(dec_lane), .a(in_a), .amt(in_b[5:0]), .y(y_shift));
  wsel_misc   u_msc (.kind(dec_kind), .lane(dec_lane), .a(in_a), .b(in_b), .y(y_misc));

  always_comb begin
    case (dec_kind)
      K_ADD, K_SUB, K_MUL:  y_sel = y_arith;
      K_SHL, K_SHR, K_SAR:  y_sel = y_shift;
      default:              y_sel = y_misc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      lat_kind  <= K_NONE;
      lat_lane  <= 2'd3;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res  <= y_sel;
        lat_kind <= dec_kind;
        lat_lane <= dec_lane;
      end
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res));
  // R2
  lane_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_sized(lat_kind) && lat_lane != 2'd3) |->
      ((out_res & ~lane_mask(lat_lane)) == '0));
  // R6
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (lat_kind == K_CMPU || lat_kind == K_CMPS)) |->
      (out_res == '0 || out_res == XLEN'(1) || out_res == '1));
  // R7
  lnot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lat_kind == K_LNOT) |-> (out_res[XLEN-1:1] == '0));
endmodule

// File: tb/tb_wsel_int_alu.sv
module tb_wsel_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_res;

  typedef struct { logic [63:0] v; string tag; } exp_t;
  exp_t        sbq[$];
  int          checks = 0, errors = 0;
  logic        have_last = 1'b0;
  logic [63:0] last_val = '0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  wsel_int_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
                    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res));

  function automatic logic [63:0] clip(logic [63:0] v, int bits);
    if (bits >= 64) return v;
    return v - ((v >> bits) << bits);
  endfunction

  function automatic logic [63:0] sx(logic [63:0] v, int bits);
    return 64'($signed(v << (64 - bits)) >>> (64 - bits));
  endfunction

  function automatic logic [63:0] order3(logic lt, logic eq);
    if (lt) return 64'hFFFF_FFFF_FFFF_FFFF;
    if (eq) return 64'd0;
    return 64'd1;
  endfunction

  function automatic logic [63:0] model(logic [7:0] op, logic [63:0] a, logic [63:0] b);
    int bits;
    if (op >= 8'h03 && op <= 8'h06) begin bits = 8 << (op - 3);    return clip(a + b, bits); end
    if (op >= 8'h07 && op <= 8'h0A) begin bits = 8 << (op - 7);    return clip(a - b, bits); end
    if (op >= 8'h0B && op <= 8'h0E) begin bits = 8 << (op - 11);   return clip(a * b, bits); end
    if (op == 8'h0F || op == 8'h35) return a & b;
    if (op == 8'h10 || op == 8'h36) return a | b;
    if (op == 8'h11 || op == 8'h37) return a ^ b;
    if (op >= 8'h12 && op <= 8'h15) begin bits = 8 << (op - 8'h12); return clip(clip(a, bits) << (b % bits), bits); end
    if (op >= 8'h16 && op <= 8'h19) begin bits = 8 << (op - 8'h16); return clip(a, bits) >> (b % bits); end
    if (op >= 8'h1A && op <= 8'h1D) begin bits = 8 << (op - 8'h1A); return clip(64'($signed(sx(a, bits)) >>> (b % bits)), bits); end
    if (op == 8'h1E || op == 8'h44) return order3(a < b, a == b);
    if (op == 8'h1F || op == 8'h45) return order3($signed(a) < $signed(b), a == b);
    if (op == 8'h28) return ~a;
    if (op == 8'h29) return (a == 0) ? 64'd1 : 64'd0;
    if (op >= 8'h2A && op <= 8'h2C) return sx(a, 8 << (op - 8'h2A));
    if (op >= 8'h2D && op <= 8'h30) begin bits = 8 << (op - 8'h2D); return clip(a + b, bits); end
    if (op >= 8'h31 && op <= 8'h34) begin bits = 8 << (op - 8'h31); return clip(a * b, bits); end
    if (op >= 8'h38 && op <= 8'h3B) begin bits = 8 << (op - 8'h38); return clip(clip(a, bits) << (b % bits), bits); end
    if (op >= 8'h3C && op <= 8'h3F) begin bits = 8 << (op - 8'h3C); return clip(a, bits) >> (b % bits); end
    if (op >= 8'h40 && op <= 8'h43) begin bits = 8 << (op - 8'h40); return clip(64'($signed(sx(a, bits)) >>> (b % bits)), bits); end
    if (op == 8'h46) return a;
    if (op >= 8'h48 && op <= 8'h4B) return clip(b, 8 << (op - 8'h48));
    return 64'd0;
  endfunction

  function automatic string tag_of(logic [7:0] op);
    if (op >= 8'h03 && op <= 8'h0A) return "R2";
    if (op >= 8'h0B && op <= 8'h0E) return "R3";
    if (op >= 8'h0F && op <= 8'h11) return "R4";
    if (op >= 8'h12 && op <= 8'h1D) return "R5";
    if (op == 8'h1E || op == 8'h1F) return "R6";
    if (op == 8'h28 || op == 8'h29) return "R7";
    if (op >= 8'h2A && op <= 8'h2C) return "R8";
    if (op >= 8'h2D && op <= 8'h45) return "R9";
    if (op == 8'h46 || (op >= 8'h48 && op <= 8'h4B)) return "R10";
    return "R11";
  endfunction

  task automatic push(logic [7:0] op, logic [63:0] a, logic [63:0] b,
                      logic [63:0] expv, string tag);
    exp_t e;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    e.v = expv; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(logic [7:0] op, logic [63:0] a, logic [63:0] b);
    push(op, a, b, model(op, a, b), tag_of(op));
  endtask

  task automatic report(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        report("R12", {63'd0, out_valid}, 64'd0);
        report("R12", out_res, 64'd0);
      end else if (out_valid) begin
        if (sbq.size() == 0) report("R1", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          report(e.tag, out_res, e.v);
          have_last = 1'b1;
          last_val  = e.v;
        end
      end else if (sbq.size() > 1) begin
        report("R1", 64'd0, 64'd1);
      end else if (have_last && sbq.size() == 0) begin
        report("R1", out_res, last_val);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // hand-worked corner values
    push(8'h03, 64'hAAAA_0000_0000_00FF, 64'h5555_0000_0000_0001, 64'h0, "R2");
    push(8'h07, 64'h0, 64'h1, 64'hFF, "R2");
    push(8'h0A, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    push(8'h0C, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0100, 64'h0, "R3");
    push(8'h0F, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000, "R4");
    push(8'h12, 64'h81, 64'h9, 64'h02, "R5");
    push(8'h1A, 64'hFFFF_FFFF_FFFF_FF80, 64'h1, 64'hC0, "R5");
    push(8'h1B, 64'h8000, 64'h10, 64'h8000, "R5");
    push(8'h1D, 64'h8000_0000_0000_0000, 64'd63, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    push(8'h1E, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1, "R6");
    push(8'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    push(8'h1F, 64'h5, 64'h5, 64'h0, "R6");
    push(8'h28, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    push(8'h29, 64'h0, 64'h0, 64'h1, "R7");
    push(8'h29, 64'h100, 64'h0, 64'h0, "R7");
    push(8'h2A, 64'h1234_0080, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, "R8");
    push(8'h2C, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 64'h7FFF_FFFF, "R8");
    push(8'h2E, 64'hFFFF, 64'h2, 64'h1, "R9");
    push(8'h44, 64'h3, 64'h7, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    push(8'h46, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'hDEAD_BEEF_0123_4567, "R10");
    push(8'h49, 64'h0, 64'hFFFF_FFFF_FFFF_ABCD, 64'hABCD, "R10");
    push(8'h20, 64'h55, 64'h3, 64'h0, "R11");
    push(8'h47, 64'h55, 64'h3, 64'h0, "R11");
    // idle gap: result must hold (R1)
    repeat (4) @(negedge clk);
    // every opcode from 0x00 to 0x50 with random operands
    for (int op = 0; op <= 8'h50; op++) begin
      send(8'(op), {$urandom, $urandom}, {$urandom, $urandom});
      send(8'(op), {56'd0, 8'($urandom)}, {58'd0, 6'($urandom)});
    end
    // random traffic with gaps
    for (int i = 0; i < 600; i++) begin
      send(8'($urandom_range(0, 8'h4F)), {$urandom, $urandom}, {$urandom, $urandom});
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (sbq.size() != 0) report("R1", 64'(sbq.size()), 64'd0);
    finish_run();
  end
endmodule